// File: doc/BRIEF.md
# Machine Clock Source Sequencer

This block decides which of three clock sources drives the machine clock: a slow sub clock, the main oscillator clock, or a multiplied clock from the PLL. Software sets three controls. The first asks to leave the sub clock. The second chooses between the main clock and the PLL clock. The third gives a two-bit PLL multiplier code. The block registers these controls and moves the active source to match them. When it leaves the sub clock it first waits a parameterised number of cycles, so that the main oscillator can settle.

The outputs are one enable per source for the glitch-free clock multiplexer, the multiplier code of the active setting, and two flags that report the source actually in use. A busy output is high while the active setting differs from the registered request. Software polls the flags or busy to learn when a change has taken effect. A request that changes during a stabilization wait is held. The block acts on it only after the wait ends.

Top module: `clk_mode_ctrl`

## Requirements
- R1: After reset the main clock enable is high, both flags are low, busy is low and the multiplier output is 00.
- R2: The request is decoded from the controls with a fixed priority. `go_fast_i`=0 requests the sub clock whatever the value of `use_main_i`. With `go_fast_i`=1, `use_main_i`=0 requests the PLL clock and `use_main_i`=1 requests the main clock.
- R3: A change to the sub clock needs no wait. The new source is active after the second rising edge that follows the change of the controls.
- R4: When leaving the sub clock, the sub enable stays high for `STAB_CYCLES` more cycles. The main or PLL source becomes active after rising edge number `STAB_CYCLES`+2 that follows the change of the controls.
- R5: A change between the main clock and the PLL clock, and a change of the multiplier code alone, take effect after the second rising edge with no wait.
- R6: The multiplier output gives the code of the active setting: 00, 01, 10 and 11 mean x1, x2, x3 and x4. It changes only when a switch completes.
- R7: `pll_on_o` is high exactly when the PLL enable is high, and `sub_on_o` is high exactly when the sub enable is high. Both keep their old values until the switch completes.
- R8: Exactly one of `en_sub_o`, `en_main_o` and `en_pll_o` is high in every cycle.
- R9: `busy_o` is high from the first edge after a change of the controls until the enables match the request. While it is low, the enables and the multiplier output do not change.
- R10: A request that changes during a stabilization wait does not affect that wait. The block completes the switch to the target it captured when the wait began, then moves to the latest request.
- R11: The stabilization counter is reloaded each time a wait begins, so every exit from the sub clock waits the full `STAB_CYCLES`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| go_fast_i | input | 1 | 0 requests the sub clock, 1 requests the main or PLL clock |
| use_main_i | input | 1 | With go_fast_i=1: 1 selects the main clock, 0 selects the PLL clock |
| mult_i | input | 2 | Requested PLL multiplier code (00..11 = x1..x4) |
| en_sub_o | output | 1 | Sub clock source enable |
| en_main_o | output | 1 | Main clock source enable |
| en_pll_o | output | 1 | PLL clock source enable |
| mult_o | output | 2 | Multiplier code of the active setting |
| pll_on_o | output | 1 | Flag: PLL clock in use |
| sub_on_o | output | 1 | Flag: sub clock in use |
| busy_o | output | 1 | Switch in progress |

## Verification
Suppose the stabilization counter is loaded wrongly or skips a step. The sub enable then falls on an edge other than `STAB_CYCLES`+2, and an edge-exact sample at the ports shows it. If the target capture is wrong, a request that changes mid-wait shows up in the source at the end of the wait instead of one edge later. Faults in the decode or the enable logic show up within two edges as a wrong enable or a wrong flag. A stuck mismatch compare shows up as busy staying high or dropping too early.

// File: rtl/clk_mode_pkg.sv
package clk_mode_pkg;

    typedef enum logic [1:0] {
        SRC_SUB  = 2'd0,
        SRC_MAIN = 2'd1,
        SRC_PLL  = 2'd2
    } src_e;

    localparam int NUM_SRC = 3;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } phase_e;

    typedef struct packed {
        phase_e     phase;
        src_e       req_src;
        logic [1:0] req_mult;
        src_e       tgt_src;
        logic [1:0] tgt_mult;
        src_e       act_src;
        logic [1:0] act_mult;
    } ctl_state_t;

endpackage

// File: rtl/clk_mode_decode.sv
module clk_mode_decode
    import clk_mode_pkg::*;
(
    input  logic go_fast_i,
    input  logic use_main_i,
    output src_e src_o
);
    // The sub request wins over the PLL/main choice.
    always_comb begin
        if (!go_fast_i)
            src_o = SRC_SUB;
        else if (!use_main_i)
            src_o = SRC_PLL;
        else
            src_o = SRC_MAIN;
    end
endmodule

// File: rtl/clk_mode_stab_timer.sv
module clk_mode_stab_timer #(
    parameter int STAB_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic run_i,
    output logic done_o
);
    localparam int CW = (STAB_CYCLES < 2) ? 1 : $clog2(STAB_CYCLES + 1);
    localparam logic [CW-1:0] RELOAD = CW'(STAB_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = RELOAD;
        else if (run_i && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign done_o = (cnt_q == '0);
endmodule

// File: rtl/clk_mode_onehot.sv
module clk_mode_onehot
    import clk_mode_pkg::*;
(
    input  src_e               src_i,
    output logic [NUM_SRC-1:0] en_o
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_en
        assign en_o[i] = (src_i == src_e'(i));
    end
endmodule

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl
    import clk_mode_pkg::*;
#(
    parameter int STAB_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go_fast_i,
    input  logic       use_main_i,
    input  logic [1:0] mult_i,
    output logic       en_sub_o,
    output logic       en_main_o,
    output logic       en_pll_o,
    output logic [1:0] mult_o,
    output logic       pll_on_o,
    output logic       sub_on_o,
    output logic       busy_o
);
    ctl_state_t         st_d, st_q;
    src_e               dec_src;
    logic               tmr_load;
    logic               tmr_done;
    logic               mismatch;
    logic [NUM_SRC-1:0] en_vec;

    clk_mode_decode u_decode (
        .go_fast_i  (go_fast_i),
        .use_main_i (use_main_i),
        .src_o      (dec_src)
    );

    clk_mode_stab_timer #(.STAB_CYCLES(STAB_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .run_i  (st_q.phase == ST_WAIT),
        .done_o (tmr_done)
    );

    assign mismatch = (st_q.req_src != st_q.act_src) || (st_q.req_mult != st_q.act_mult);

    always_comb begin
        st_d          = st_q;
        st_d.req_src  = dec_src;
        st_d.req_mult = mult_i;
        tmr_load      = 1'b0;
        unique case (st_q.phase)
            ST_IDLE: begin
                if (mismatch) begin
                    if (st_q.act_src == SRC_SUB && st_q.req_src != SRC_SUB) begin
                        // The oscillator must settle first: freeze the target.
                        st_d.phase    = ST_WAIT;
                        st_d.tgt_src  = st_q.req_src;
                        st_d.tgt_mult = st_q.req_mult;
                        tmr_load      = 1'b1;
                    end else begin
                        st_d.act_src  = st_q.req_src;
                        st_d.act_mult = st_q.req_mult;
                    end
                end
            end
            ST_WAIT: begin
                if (tmr_done) begin
                    st_d.act_src  = st_q.tgt_src;
                    st_d.act_mult = st_q.tgt_mult;
                    st_d.phase    = ST_IDLE;
                end
            end
            default: st_d.phase = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase    <= ST_IDLE;
            st_q.req_src  <= SRC_MAIN;
            st_q.req_mult <= 2'b00;
            st_q.tgt_src  <= SRC_MAIN;
            st_q.tgt_mult <= 2'b00;
            st_q.act_src  <= SRC_MAIN;
            st_q.act_mult <= 2'b00;
        end else begin
            st_q <= st_d;
        end
    end

    clk_mode_onehot u_onehot (
        .src_i (st_q.act_src),
        .en_o  (en_vec)
    );

    assign en_sub_o  = en_vec[SRC_SUB];
    assign en_main_o = en_vec[SRC_MAIN];
    assign en_pll_o  = en_vec[SRC_PLL];
    assign mult_o    = st_q.act_mult;
    assign pll_on_o  = (st_q.act_src == SRC_PLL);
    assign sub_on_o  = (st_q.act_src == SRC_SUB);
    assign busy_o    = (st_q.phase == ST_WAIT) || mismatch;
endmodule

// File: rtl/clk_mode_ctrl_chk.sv
module clk_mode_ctrl_chk #(
    parameter int STAB_CYCLES = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       go_fast_i,
    input logic       en_sub_o,
    input logic       en_main_o,
    input logic       en_pll_o,
    input logic [1:0] mult_o,
    input logic       pll_on_o,
    input logic       sub_on_o,
    input logic       busy_o
);
    logic [31:0] sub_busy_cnt;

    // Counts the samples spent on the sub clock with a switch pending.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sub_busy_cnt <= '0;
        else if (en_sub_o && busy_o && sub_busy_cnt != 32'hFFFF_FFFF)
            sub_busy_cnt <= sub_busy_cnt + 1'b1;
        else if (!(en_sub_o && busy_o))
            sub_busy_cnt <= '0;
    end

    a_r8_one_source: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({en_sub_o, en_main_o, en_pll_o}) == 1);

    a_r7_flags_track: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_on_o == en_pll_o) && (sub_on_o == en_sub_o));

    a_r4_sub_exit_waits: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_sub_o) |-> ($past(sub_busy_cnt) >= 32'(STAB_CYCLES)));

    a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> ($stable({en_sub_o, en_main_o, en_pll_o}) && $stable(mult_o)));

    a_r3_sub_entry_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (!go_fast_i && !en_sub_o && !busy_o) |=> ##1 en_sub_o);
endmodule

bind clk_mode_ctrl clk_mode_ctrl_chk #(.STAB_CYCLES(STAB_CYCLES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_fast_i (go_fast_i),
    .en_sub_o  (en_sub_o),
    .en_main_o (en_main_o),
    .en_pll_o  (en_pll_o),
    .mult_o    (mult_o),
    .pll_on_o  (pll_on_o),
    .sub_on_o  (sub_on_o),
    .busy_o    (busy_o)
);

// File: tb/tb_clk_mode_ctrl.sv
`timescale 1ns/1ps
module tb_clk_mode_ctrl;
    localparam int S = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       go_fast = 1'b1;
    logic       use_main = 1'b1;
    logic [1:0] mult = 2'b00;
    logic       en_sub, en_main, en_pll, pll_on, sub_on, busy;
    logic [1:0] mult_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    clk_mode_ctrl #(.STAB_CYCLES(S)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_fast_i  (go_fast),
        .use_main_i (use_main),
        .mult_i     (mult),
        .en_sub_o   (en_sub),
        .en_main_o  (en_main),
        .en_pll_o   (en_pll),
        .mult_o     (mult_out),
        .pll_on_o   (pll_on),
        .sub_on_o   (sub_on),
        .busy_o     (busy)
    );

    // {en_sub, en_main, en_pll, sub_on, pll_on, busy, mult}
    function automatic logic [7:0] snap();
        return {en_sub, en_main, en_pll, sub_on, pll_on, busy, mult_out};
    endfunction

    // src: 0 sub, 1 main, 2 pll
    function automatic logic [7:0] ev(input int src, input logic b, input logic [1:0] m);
        return {src == 0, src == 1, src == 2, src == 0, src == 2, b, m};
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic drive(input logic f, input logic d, input logic [1:0] m);
        @(negedge clk);
        go_fast = f; use_main = d; mult = m;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        chk("R1 reset state", snap(), ev(1, 1'b0, 2'b00));
    endtask

    task automatic t_to_pll();
        drive(1'b1, 1'b0, 2'b10);
        edges(1);
        chk("R7 flags lag during switch", snap(), ev(1, 1'b1, 2'b00));
        edges(1);
        chk("R5 main to pll after two edges", snap(), ev(2, 1'b0, 2'b10));
    endtask

    task automatic t_mult();
        drive(1'b1, 1'b0, 2'b11);
        edges(1);
        chk("R6 multiplier held while busy", snap(), ev(2, 1'b1, 2'b10));
        edges(1);
        chk("R6 multiplier x4 code applied", snap(), ev(2, 1'b0, 2'b11));
    endtask

    task automatic t_pll_to_sub();
        drive(1'b0, 1'b0, 2'b11);
        edges(1);
        chk("R3 pll still active one edge in", snap(), ev(2, 1'b1, 2'b11));
        edges(1);
        chk("R2 R3 sub wins, no wait", snap(), ev(0, 1'b0, 2'b11));
    endtask

    task automatic t_sub_exit_main();
        drive(1'b1, 1'b1, 2'b00);
        edges(1);
        chk("R9 busy on sub exit", snap(), ev(0, 1'b1, 2'b11));
        edges(S);
        chk("R4 sub held for full wait", snap(), ev(0, 1'b1, 2'b11));
        edges(1);
        chk("R4 main after wait", snap(), ev(1, 1'b0, 2'b00));
    endtask

    task automatic t_onehot_sweep();
        drive(1'b1, 1'b0, 2'b10);
        for (int i = 0; i < 4; i++) begin
            edges(1);
            chk("R8 single enable", 8'($countones({en_sub, en_main, en_pll})), 8'd1);
        end
        drive(1'b1, 1'b1, 2'b10);
        for (int i = 0; i < 4; i++) begin
            edges(1);
            chk("R8 single enable", 8'($countones({en_sub, en_main, en_pll})), 8'd1);
        end
        chk("R5 pll back to main", snap(), ev(1, 1'b0, 2'b10));
    endtask

    task automatic t_main_to_sub();
        drive(1'b0, 1'b1, 2'b10);
        edges(1);
        chk("R2 sub request with main select", snap(), ev(1, 1'b1, 2'b10));
        edges(1);
        chk("R3 main to sub immediate", snap(), ev(0, 1'b0, 2'b10));
    endtask

    task automatic t_midwait();
        drive(1'b1, 1'b0, 2'b01);
        edges(3);
        drive(1'b1, 1'b1, 2'b00);
        edges(S - 2);
        chk("R11 reloaded wait still on sub", snap(), ev(0, 1'b1, 2'b10));
        edges(1);
        chk("R10 captured pll target applied", snap(), ev(2, 1'b1, 2'b01));
        edges(1);
        chk("R10 later request applied after", snap(), ev(1, 1'b0, 2'b00));
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        edges(1);
        t_reset();
        t_to_pll();
        t_mult();
        t_pll_to_sub();
        t_sub_exit_main();
        t_onehot_sweep();
        t_main_to_sub();
        t_midwait();
        edges(2);
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule